// File: doc/BRIEF.md
# Processor Low-Power Mode Controller

This block sequences a processor core through four power states: full power, doze, nap and sleep. Software chooses a low-power state through a power-save enable and a two-bit mode selection. The block then drives enable lines for the functional units, the bus snoop logic, the time base/decrementer and the PLL, and a clock-stop request that lets system logic halt the clocks in sleep. A set of wake events brings the core back to full power. The events that count as a wake depend on the current state.

Nap keeps only the time base and the PLL alive. When the snoop grant input is withdrawn during nap, the controller falls back to doze so that snooping runs again. When the grant returns, it goes back to nap. Sleep stops everything and asks for the clocks to be stopped. A wake from sleep is only taken once the PLL reports lock again. Every wake passes through a fixed-length recovery window. At the end of that window all unit enables rise together and a one-cycle completion pulse is given. A hard or soft reset request overrides everything else.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After rst_n is released, and in the cycle after rst_req is sampled high in any state, the state is full power, wake_done is low and the record of a nap-to-doze fallback is cleared. rst_req takes precedence over every other input.
- R2: In full power, with save_en high, mode_sel 2'b00 enters doze, 2'b01 enters nap and 2'b10 enters sleep on the next clock edge. mode_sel 2'b11, or save_en low, leaves the state at full power.
- R3: pwr_state reports the state as follows: 0 is full power, 1 is doze, 2 is nap, 3 is sleep and 4 is wake recovery.
- R4: The enables {snoop_en, tbase_en, pll_en, clk_stop_req} take these values: 1110 in full, doze and wake recovery; 0110 in nap; 0001 in sleep. unit_en is all zero in every state except full power.
- R5: In full power, with dyn_pm_en high, unit_en[i] is the inverse of unit_idle[i] for each unit independently. With dyn_pm_en low, all of unit_en is high.
- R6: In doze or nap, a high level on irq_ext, irq_smi, dec_exc or mchk moves the state to wake recovery on the next edge.
- R7: Wake recovery lasts exactly WAKE_LAT cycles (4 by default). The state then becomes full power, all unit_en rise together and wake_done is high for that first full-power cycle only.
- R8: In nap, snoop_grant low moves the state to doze. In a doze that was entered this way, snoop_grant high returns the state to nap. In a doze entered directly from full power, snoop_grant has no effect.
- R9: In sleep, no wake event is taken while pll_locked is low. dec_exc is never a wake source from sleep. With pll_locked high, irq_ext, irq_smi or mchk moves the state to wake recovery.
- R10: In nap, a wake event sampled together with snoop_grant low leads to wake recovery, not to doze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| save_en | input | 1 | Power-save enable from the control register |
| mode_sel | input | 2 | Low-power mode selection |
| dyn_pm_en | input | 1 | Enables per-unit idle gating in full power |
| irq_ext | input | 1 | External interrupt |
| irq_smi | input | 1 | System-management interrupt |
| dec_exc | input | 1 | Decrementer exception |
| mchk | input | 1 | Machine check |
| rst_req | input | 1 | Hard or soft reset request |
| snoop_grant | input | 1 | Snoop grant from the system; low withdraws it |
| pll_locked | input | 1 | PLL lock indication |
| unit_idle | input | NUM_UNITS | Per-unit idle flags |
| unit_en | output | NUM_UNITS | Functional unit enables |
| snoop_en | output | 1 | Bus snoop logic enable |
| tbase_en | output | 1 | Time base/decrementer enable |
| pll_en | output | 1 | PLL power enable |
| clk_stop_req | output | 1 | Request to stop the PLL and system clock |
| wake_done | output | 1 | One-cycle pulse when wake recovery ends |
| pwr_state | output | 3 | Current state code |

## Verification
The mode selection is swept over all four codes with save_en both high and low. This separates the three entry codes from the reserved code and from the disabled case. Each of the four wake sources is applied in doze, nap and sleep, and in sleep with the PLL both unlocked and locked. This exposes any state that accepts the wrong source, such as the decrementer in sleep, or that wakes before relock. The recovery window is traced cycle by cycle to catch a window that is one cycle short or long. All idle patterns are swept with dynamic gating both on and off, which shows a gating fault that affects only one unit. Snoop-grant toggles are applied in nap, in a doze reached from nap and in a doze entered directly, and reset is applied from every state. These patterns separate the fallback path from the direct doze and check that reset clears the fallback record.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        PS_FULL  = 3'd0,
        PS_DOZE  = 3'd1,
        PS_NAP   = 3'd2,
        PS_SLEEP = 3'd3,
        PS_WAKE  = 3'd4
    } pwr_state_e;

    localparam logic [1:0] SEL_DOZE  = 2'b00;
    localparam logic [1:0] SEL_NAP   = 2'b01;
    localparam logic [1:0] SEL_SLEEP = 2'b10;

    typedef struct packed {
        pwr_state_e st;
        logic       via_nap;
        logic       done;
    } pwr_regs_t;

    typedef struct packed {
        logic snoop;
        logic tbase;
        logic pll;
        logic stop;
    } aux_en_t;

endpackage

// File: rtl/pwr_wake_sel.sv
module pwr_wake_sel
    import pwr_mode_pkg::*;
(
    input  pwr_state_e st,
    input  logic       irq_ext,
    input  logic       irq_smi,
    input  logic       dec_exc,
    input  logic       mchk,
    input  logic       pll_locked,
    output logic       wake_ok
);

    logic async_evt;

    always_comb begin
        async_evt = irq_ext | irq_smi | mchk;
        unique case (st)
            PS_DOZE, PS_NAP: wake_ok = async_evt | dec_exc;
            PS_SLEEP:        wake_ok = async_evt & pll_locked;
            default:         wake_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    localparam int CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] LAST = CW'(LAT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = '0;
        expire = 1'b0;
        if (run) begin
            if (cnt_q == LAST) begin
                expire = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7: every recovery window starts counting from zero
    assert_window_starts_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (cnt_q == '0));

    // R7: the count stays inside the window
    assert_count_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/pwr_unit_gate.sv
module pwr_unit_gate #(
    parameter int NUM_UNITS = 4
) (
    input  logic                 full_on,
    input  logic                 dyn_pm_en,
    input  logic [NUM_UNITS-1:0] unit_idle,
    output logic [NUM_UNITS-1:0] unit_en
);

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        logic keep_on;
        always_comb begin
            keep_on    = ~dyn_pm_en | ~unit_idle[g];
            unit_en[g] = full_on & keep_on;
        end
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    parameter int WAKE_LAT  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 save_en,
    input  logic [1:0]           mode_sel,
    input  logic                 dyn_pm_en,
    input  logic                 irq_ext,
    input  logic                 irq_smi,
    input  logic                 dec_exc,
    input  logic                 mchk,
    input  logic                 rst_req,
    input  logic                 snoop_grant,
    input  logic                 pll_locked,
    input  logic [NUM_UNITS-1:0] unit_idle,
    output logic [NUM_UNITS-1:0] unit_en,
    output logic                 snoop_en,
    output logic                 tbase_en,
    output logic                 pll_en,
    output logic                 clk_stop_req,
    output logic                 wake_done,
    output logic [2:0]           pwr_state
);

    pwr_regs_t r_d, r_q;
    logic      wake_ok;
    logic      expire;
    logic      in_wake;
    aux_en_t   aux;

    assign in_wake = (r_q.st == PS_WAKE);

    pwr_wake_sel u_wake_sel (
        .st         (r_q.st),
        .irq_ext    (irq_ext),
        .irq_smi    (irq_smi),
        .dec_exc    (dec_exc),
        .mchk       (mchk),
        .pll_locked (pll_locked),
        .wake_ok    (wake_ok)
    );

    pwr_wake_timer #(.LAT(WAKE_LAT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (in_wake),
        .expire (expire)
    );

    pwr_unit_gate #(.NUM_UNITS(NUM_UNITS)) u_gate (
        .full_on   (r_q.st == PS_FULL),
        .dyn_pm_en (dyn_pm_en),
        .unit_idle (unit_idle),
        .unit_en   (unit_en)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (rst_req) begin
            r_d.st      = PS_FULL;
            r_d.via_nap = 1'b0;
        end else begin
            unique case (r_q.st)
                PS_FULL: begin
                    r_d.via_nap = 1'b0;
                    if (save_en) begin
                        case (mode_sel)
                            SEL_DOZE:  r_d.st = PS_DOZE;
                            SEL_NAP:   r_d.st = PS_NAP;
                            SEL_SLEEP: r_d.st = PS_SLEEP;
                            default:   r_d.st = PS_FULL;
                        endcase
                    end
                end
                PS_DOZE: begin
                    if (wake_ok) begin
                        r_d.st      = PS_WAKE;
                        r_d.via_nap = 1'b0;
                    end else if (r_q.via_nap && snoop_grant) begin
                        r_d.st      = PS_NAP;
                        r_d.via_nap = 1'b0;
                    end
                end
                PS_NAP: begin
                    if (wake_ok) begin
                        r_d.st = PS_WAKE;
                    end else if (!snoop_grant) begin
                        r_d.st      = PS_DOZE;
                        r_d.via_nap = 1'b1;
                    end
                end
                PS_SLEEP: begin
                    if (wake_ok) r_d.st = PS_WAKE;
                end
                PS_WAKE: begin
                    if (expire) begin
                        r_d.st   = PS_FULL;
                        r_d.done = 1'b1;
                    end
                end
                default: begin
                    r_d.st      = PS_FULL;
                    r_d.via_nap = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= PS_FULL;
            r_q.via_nap <= 1'b0;
            r_q.done    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.st)
            PS_NAP:   aux = '{snoop: 1'b0, tbase: 1'b1, pll: 1'b1, stop: 1'b0};
            PS_SLEEP: aux = '{snoop: 1'b0, tbase: 1'b0, pll: 1'b0, stop: 1'b1};
            default:  aux = '{snoop: 1'b1, tbase: 1'b1, pll: 1'b1, stop: 1'b0};
        endcase
    end

    assign snoop_en     = aux.snoop;
    assign tbase_en     = aux.tbase;
    assign pll_en       = aux.pll;
    assign clk_stop_req = aux.stop;
    assign wake_done    = r_q.done;
    assign pwr_state    = r_q.st;

    // R1: a reset request always lands in full power without a completion pulse
    assert_reset_to_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (pwr_state == 3'd0) && !wake_done);

    // R2: without save_en the block stays in full power
    assert_hold_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd0 && !save_en && !rst_req) |=> (pwr_state == 3'd0));

    // R4: units are gated off in every non-full state
    assert_units_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 3'd0) |-> (unit_en == '0));

    // R7: the completion pulse only follows recovery
    assert_done_after_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |-> ($past(pwr_state) == 3'd4) && (pwr_state == 3'd0));

    // R8: grant withdrawal in nap falls back to doze
    assert_nap_fallback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd2 && !snoop_grant && !irq_ext && !irq_smi && !dec_exc
         && !mchk && !rst_req) |=> (pwr_state == 3'd1));

    // R9: no exit from sleep while unlocked
    assert_sleep_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd3 && !pll_locked && !rst_req) |=> (pwr_state == 3'd3));

    // R9: clock stop is requested in sleep only, with the PLL enable dropped
    assert_stop_only_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop_req |-> (pwr_state == 3'd3) && !pll_en && !tbase_en);

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb_top;

    localparam int NU = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          save_en, dyn_pm_en, irq_ext, irq_smi, dec_exc, mchk;
    logic          rst_req, snoop_grant, pll_locked;
    logic [1:0]    mode_sel;
    logic [NU-1:0] unit_idle, unit_en;
    logic          snoop_en, tbase_en, pll_en, clk_stop_req, wake_done;
    logic [2:0]    pwr_state;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pwr_mode_ctrl #(.NUM_UNITS(NU), .WAKE_LAT(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .save_en(save_en), .mode_sel(mode_sel),
        .dyn_pm_en(dyn_pm_en), .irq_ext(irq_ext), .irq_smi(irq_smi),
        .dec_exc(dec_exc), .mchk(mchk), .rst_req(rst_req),
        .snoop_grant(snoop_grant), .pll_locked(pll_locked),
        .unit_idle(unit_idle), .unit_en(unit_en), .snoop_en(snoop_en),
        .tbase_en(tbase_en), .pll_en(pll_en), .clk_stop_req(clk_stop_req),
        .wake_done(wake_done), .pwr_state(pwr_state)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic clear_inputs;
        save_en = 0; mode_sel = 2'b00; dyn_pm_en = 0;
        irq_ext = 0; irq_smi = 0; dec_exc = 0; mchk = 0; rst_req = 0;
        snoop_grant = 1; pll_locked = 1; unit_idle = '0;
    endtask

    // expected {snoop,tbase,pll,stop} per state code (R4)
    function automatic int aux_exp(input int st);
        if (st == 2) return 4'b0110;
        if (st == 3) return 4'b0001;
        return 4'b1110;
    endfunction

    task automatic enter(input logic [1:0] m);
        save_en = 1; mode_sel = m;
        tick;
        save_en = 0;
    endtask

    task automatic pulse(input int src);
        case (src)
            0: irq_ext = 1;
            1: irq_smi = 1;
            2: dec_exc = 1;
            default: mchk = 1;
        endcase
        tick;
        irq_ext = 0; irq_smi = 0; dec_exc = 0; mchk = 0;
    endtask

    task automatic do_reset;
        rst_req = 1;
        tick;
        rst_req = 0;
    endtask

    task automatic follow_wake;
        check("R6 enter recovery", pwr_state, 4);
        check("R4 units off in recovery", unit_en, 0);
        for (int c = 1; c < 4; c++) begin
            tick;
            check("R7 recovery length", pwr_state, 4);
        end
        tick;
        check("R7 full after recovery", pwr_state, 0);
        check("R7 wake_done pulse", wake_done, 1);
        check("R7 units together", unit_en, (1 << NU) - 1);
        tick;
        check("R7 wake_done single", wake_done, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        check("R1 reset state", pwr_state, 0);
        check("R1 reset wake_done", wake_done, 0);
        check("R4 reset aux", {snoop_en, tbase_en, pll_en, clk_stop_req}, aux_exp(0));
        check("R5 reset units on", unit_en, (1 << NU) - 1);

        // R2, R3, R4: entry sweep over mode codes and save_en
        for (int se = 0; se < 2; se++) begin
            for (int m = 0; m < 4; m++) begin
                int exp_st;
                exp_st = (se == 0 || m == 3) ? 0 : m + 1;
                save_en = 1'(se); mode_sel = 2'(m);
                tick;
                save_en = 0;
                check("R2 entry", pwr_state, exp_st);
                check("R4 aux enables", {snoop_en, tbase_en, pll_en, clk_stop_req}, aux_exp(exp_st));
                check("R4 units", unit_en, exp_st == 0 ? (1 << NU) - 1 : 0);
                do_reset();
                check("R1 reset from state", pwr_state, 0);
                check("R1 no pulse", wake_done, 0);
            end
        end

        // R6, R7: every source from doze and nap
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                enter(2'(m));
                tick;
                check("R6 idle holds", pwr_state, m + 1);
                pulse(s);
                follow_wake();
            end
        end

        // R9: sleep needs lock, ignores decrementer
        for (int s = 0; s < 4; s++) begin
            if (s == 2) continue;
            enter(2'b10);
            pll_locked = 0;
            pulse(s);
            check("R9 unlocked ignored", pwr_state, 3);
            pll_locked = 1;
            pulse(2);
            check("R9 decrementer ignored", pwr_state, 3);
            pulse(s);
            follow_wake();
        end
        enter(2'b10);
        pll_locked = 0;
        do_reset();
        check("R1 reset from unlocked sleep", pwr_state, 0);
        pll_locked = 1;

        // R1: reset during recovery
        enter(2'b00);
        pulse(0);
        tick;
        do_reset();
        check("R1 reset in recovery", pwr_state, 0);
        check("R1 reset in recovery pulse", wake_done, 0);

        // R8: grant handling
        enter(2'b01);
        snoop_grant = 0;
        tick;
        check("R8 nap falls to doze", pwr_state, 1);
        check("R8 snoop back on", snoop_en, 1);
        tick;
        check("R8 doze holds without grant", pwr_state, 1);
        snoop_grant = 1;
        tick;
        check("R8 grant returns nap", pwr_state, 2);
        snoop_grant = 0;
        tick;
        do_reset();
        snoop_grant = 1;
        enter(2'b00);
        tick;
        check("R8 direct doze ignores grant / R1 flag cleared", pwr_state, 1);
        snoop_grant = 0;
        tick;
        snoop_grant = 1;
        tick;
        check("R8 direct doze ignores toggle", pwr_state, 1);
        do_reset();

        // R10: wake beats grant loss
        enter(2'b01);
        snoop_grant = 0;
        pulse(1);
        snoop_grant = 1;
        check("R10 wake over fallback", pwr_state, 4);
        follow_wake();

        // R5: idle sweep
        for (int d = 0; d < 2; d++) begin
            for (int v = 0; v < (1 << NU); v++) begin
                dyn_pm_en = 1'(d); unit_idle = NU'(v);
                #1;
                check("R5 idle gating", unit_en, d ? (~v) & ((1 << NU) - 1) : (1 << NU) - 1);
            end
        end
        enter(2'b00);
        dyn_pm_en = 1; unit_idle = '0;
        #1;
        check("R4 gating off outside full", unit_en, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule